// File: doc/BRIEF.md
# Serialized Interrupt Peripheral Agent

This block is the device end of a single-wire serialized interrupt bus. It watches the shared open-drain line on every rising clock edge. When it sees a start frame, it counts fixed three-clock frames. In the sample clock of its own frame it pulls the line low while its local interrupt request is high. In the following clock it drives the line high to speed recovery, and in the turnaround clock it floats the line. The line level is passed in as `lineIn`. The block drives the line through `driveEn` (output enable) and `driveVal` (level), so an external tri-state buffer with a pull-up makes the wired line.

Between data phases the agent times each low pulse that the host sends. A two-clock stop pulse selects quiet mode and a three-clock stop pulse selects continuous mode. The current mode is reported on `modeQuiet`. Only in quiet mode, and only after a stop pulse has been seen, may the agent request a new cycle. It does so by pulling the line low for one clock. The host then stretches that pulse into a full start frame. The frame number of the agent is the parameter `SLOT`, and the number of data frames in a cycle is `NUM_FRAMES`.

Sample indices below count rising clock edges. A value the agent decides at edge n is seen on the line at edge n+1.

Top module: `serirq_agent`

## Requirements
- R1: While `rstN` is low, `driveEn` is 0. After reset the agent is in continuous mode (`modeQuiet` = 0).
- R2: Outside a data phase, a run of exactly two low samples followed by a high sample sets `modeQuiet` to 1 from that high sample's edge onward.
- R3: Outside a data phase, a run of exactly three low samples followed by a high sample clears `modeQuiet` to 0 from that edge onward.
- R4: A single-sample low pulse outside a data phase leaves `modeQuiet` unchanged. The mode changes only at the end of a two- or three-sample low run seen outside a data phase.
- R5: Outside a data phase, a low run of four or more samples is a start frame. Let H be its first high sample. H is the start frame's recovery clock and H+1 is its turnaround clock. Frame k (0 ≤ k < `NUM_FRAMES`) takes samples H+2+3k (sample), H+3+3k (recovery) and H+4+3k (turnaround). Low runs inside the data phase are not timed.
- R6: At sample H+2+3·`SLOT` the agent drives low when `irqIn` was 1 at the edge that opens that clock (edge H+1+3·`SLOT`). Otherwise it leaves the line released. In the sample clocks of all other frames it stays released.
- R7: A clock in which the agent drove low is followed by one clock of driving high (`driveEn`=1, `driveVal`=1) and then by release.
- R8: In continuous mode the agent never drives the line outside a data phase.
- R9: In quiet mode, after a stop pulse ending at high sample R, with `irqIn` high, the agent drives low for exactly one clock, at sample R+2 at the earliest, and then releases the line.
- R10: In quiet mode with `irqIn` low, the agent does not drive the line outside a data phase.
- R11: Between the end of a data phase and the next stop pulse, the agent makes no start request, even in quiet mode with `irqIn` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all sampling and driving happen on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 1 | Local interrupt request, active high |
| lineIn | input | 1 | Sampled level of the shared serialized interrupt line |
| driveEn | output | 1 | Output enable for the line buffer; 0 means tri-stated |
| driveVal | output | 1 | Level driven onto the line while `driveEn` is 1 |
| modeQuiet | output | 1 | 1 in quiet mode, 0 in continuous mode |

## Verification
Every drive decision is registered. The value that `driveEn`/`driveVal` shows after edge n is what the line carries at sample n+1. The mode flag follows one edge after the high sample that ends a stop pulse. The slot drive appears two samples after the end of the start frame plus three per frame, with recovery and turnaround in the next two samples. The quiet-mode start pulse appears after the second high sample that follows the stop. The bench steps the host one sample at a time at the falling edge, and after each step it reads the outputs for the next sample. It compares them with values worked out from H, R, `SLOT` and the frame arithmetic. It sweeps start-frame lengths, both request levels and both stop widths.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

  // Minimum low run, in samples, that counts as a start frame.
  localparam int START_MIN = 4;
  // Saturation of the consecutive-high counter used for the start holdoff.
  localparam int HIGH_SAT  = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } agentState_t;

  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_REC    = 2'd1,
    PH_TA     = 2'd2
  } framePhase_t;

  typedef struct packed {
    logic runInc;
    logic runClr;
    logic highInc;
    logic highClr;
    logic setQuiet;
    logic setCont;
    logic clrStop;
    logic frameLoad;
    logic phaseAdv;
    logic drvLow;
    logic drvHigh;
    logic drvRel;
  } ctlStrobe_t;

endpackage

// File: rtl/serirq_dp.sv
module serirq_dp
  import serirq_pkg::*;
#(
  parameter int NUM_FRAMES = 21
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ctlStrobe_t                          strobe,
  output logic [$clog2(START_MIN+1)-1:0]      lowRun,
  output logic [$clog2(HIGH_SAT+1)-1:0]       highRun,
  output logic [$clog2(NUM_FRAMES+1)-1:0]     frameIdx,
  output framePhase_t                         phase,
  output logic                                modeQuiet,
  output logic                                stopSeen,
  output logic                                driveEn,
  output logic                                driveVal
);

  localparam int RUN_W  = $clog2(START_MIN+1);
  localparam int HIGH_W = $clog2(HIGH_SAT+1);
  localparam int FR_W   = $clog2(NUM_FRAMES+1);
  localparam logic [RUN_W-1:0]  RUN_TOP  = RUN_W'(START_MIN);
  localparam logic [HIGH_W-1:0] HIGH_TOP = HIGH_W'(HIGH_SAT);

  // Saturating low-run counter: only widths up to START_MIN matter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun <= '0;
    end else if (strobe.runClr) begin
      lowRun <= '0;
    end else if (strobe.runInc && lowRun != RUN_TOP) begin
      lowRun <= lowRun + RUN_W'(1);
    end
  end

  // Saturating high-run counter for the start-request holdoff.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highRun <= '0;
    end else if (strobe.highClr) begin
      highRun <= '0;
    end else if (strobe.highInc && highRun != HIGH_TOP) begin
      highRun <= highRun + HIGH_W'(1);
    end
  end

  // Bus mode, plus a flag saying whether a stop pulse closed the last cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQuiet <= 1'b0;
      stopSeen  <= 1'b0;
    end else begin
      if (strobe.setQuiet) begin
        modeQuiet <= 1'b1;
      end else if (strobe.setCont) begin
        modeQuiet <= 1'b0;
      end
      if (strobe.setQuiet || strobe.setCont) begin
        stopSeen <= 1'b1;
      end else if (strobe.clrStop) begin
        stopSeen <= 1'b0;
      end
    end
  end

  // Frame position: the frame index steps when recovery turns into turnaround.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_TA;
      frameIdx <= '0;
    end else if (strobe.frameLoad) begin
      phase    <= PH_TA;
      frameIdx <= '0;
    end else if (strobe.phaseAdv) begin
      unique case (phase)
        PH_TA:     phase <= PH_SAMPLE;
        PH_SAMPLE: phase <= PH_REC;
        default: begin
          phase    <= PH_TA;
          frameIdx <= frameIdx + FR_W'(1);
        end
      endcase
    end
  end

  // Registered line drive.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveEn  <= 1'b0;
      driveVal <= 1'b1;
    end else if (strobe.drvLow) begin
      driveEn  <= 1'b1;
      driveVal <= 1'b0;
    end else if (strobe.drvHigh) begin
      driveEn  <= 1'b1;
      driveVal <= 1'b1;
    end else if (strobe.drvRel) begin
      driveEn  <= 1'b0;
      driveVal <= 1'b1;
    end
  end

endmodule

// File: rtl/serirq_ctrl.sv
module serirq_ctrl
  import serirq_pkg::*;
#(
  parameter int NUM_FRAMES = 21,
  parameter int SLOT       = 1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                lineIn,
  input  logic                                irqIn,
  input  logic [$clog2(START_MIN+1)-1:0]      lowRun,
  input  logic [$clog2(HIGH_SAT+1)-1:0]       highRun,
  input  logic [$clog2(NUM_FRAMES+1)-1:0]     frameIdx,
  input  framePhase_t                         phase,
  input  logic                                modeQuiet,
  input  logic                                stopSeen,
  input  logic                                lowNow,
  output ctlStrobe_t                          strobe,
  output logic                                inData
);

  localparam int RUN_W  = $clog2(START_MIN+1);
  localparam int HIGH_W = $clog2(HIGH_SAT+1);
  localparam int FR_W   = $clog2(NUM_FRAMES+1);
  localparam logic [FR_W-1:0]  LAST_FR = FR_W'(NUM_FRAMES);
  localparam logic [FR_W-1:0]  MY_FR   = FR_W'(SLOT);
  localparam logic [RUN_W-1:0] STOP_Q  = RUN_W'(2);
  localparam logic [RUN_W-1:0] STOP_C  = RUN_W'(3);
  localparam logic [RUN_W-1:0] START_W = RUN_W'(START_MIN);

  agentState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign inData = (state == ST_DATA);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        strobe.drvRel = 1'b1;
        if (!lineIn) begin
          strobe.runInc  = 1'b1;
          strobe.highClr = 1'b1;
        end else begin
          strobe.runClr  = 1'b1;
          strobe.highInc = 1'b1;
          if (lowRun == STOP_Q) begin
            strobe.setQuiet = 1'b1;
          end else if (lowRun == STOP_C) begin
            strobe.setCont = 1'b1;
          end else if (lowRun >= START_W) begin
            strobe.frameLoad = 1'b1;
            strobe.clrStop   = 1'b1;
            stateNext        = ST_DATA;
          end
          // Start request: quiet mode, stop seen, line high for two samples.
          if (lowRun == '0 && highRun != HIGH_W'(0) &&
              modeQuiet && stopSeen && irqIn) begin
            strobe.drvRel = 1'b0;
            strobe.drvLow = 1'b1;
          end
        end
      end
      default: begin
        if (phase == PH_TA && frameIdx == LAST_FR) begin
          stateNext      = ST_IDLE;
          strobe.runClr  = 1'b1;
          strobe.highClr = 1'b1;
          strobe.drvRel  = 1'b1;
        end else begin
          strobe.phaseAdv = 1'b1;
          unique case (phase)
            PH_TA: begin
              if (frameIdx == MY_FR && irqIn) strobe.drvLow = 1'b1;
              else                            strobe.drvRel = 1'b1;
            end
            PH_SAMPLE: begin
              if (lowNow) strobe.drvHigh = 1'b1;
              else        strobe.drvRel  = 1'b1;
            end
            default: strobe.drvRel = 1'b1;
          endcase
        end
      end
    endcase
  end

endmodule

// File: rtl/serirq_agent.sv
module serirq_agent
  import serirq_pkg::*;
#(
  parameter int NUM_FRAMES = 21,
  parameter int SLOT       = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic irqIn,
  input  logic lineIn,
  output logic driveEn,
  output logic driveVal,
  output logic modeQuiet
);

  localparam int RUN_W  = $clog2(START_MIN+1);
  localparam int HIGH_W = $clog2(HIGH_SAT+1);
  localparam int FR_W   = $clog2(NUM_FRAMES+1);

  ctlStrobe_t        strobe;
  logic [RUN_W-1:0]  lowRun;
  logic [HIGH_W-1:0] highRun;
  logic [FR_W-1:0]   frameIdx;
  framePhase_t       phase;
  logic              stopSeen;
  logic              inData;
  logic              lowNow;

  assign lowNow = driveEn & ~driveVal;

  serirq_ctrl #(.NUM_FRAMES(NUM_FRAMES), .SLOT(SLOT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineIn    (lineIn),
    .irqIn     (irqIn),
    .lowRun    (lowRun),
    .highRun   (highRun),
    .frameIdx  (frameIdx),
    .phase     (phase),
    .modeQuiet (modeQuiet),
    .stopSeen  (stopSeen),
    .lowNow    (lowNow),
    .strobe    (strobe),
    .inData    (inData)
  );

  serirq_dp #(.NUM_FRAMES(NUM_FRAMES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lowRun    (lowRun),
    .highRun   (highRun),
    .frameIdx  (frameIdx),
    .phase     (phase),
    .modeQuiet (modeQuiet),
    .stopSeen  (stopSeen),
    .driveEn   (driveEn),
    .driveVal  (driveVal)
  );

endmodule

// File: rtl/serirq_agent_chk.sv
module serirq_agent_chk (
  input logic clk,
  input logic rstN,
  input logic lineIn,
  input logic driveEn,
  input logic driveVal,
  input logic modeQuiet,
  input logic inData
);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_release_R1: assert (!driveEn);
    end
  end

  // Mode moves only at the high sample that closes a pulse outside the data phase.
  assert_mode_on_pulse_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeQuiet) |-> ($past(lineIn) && !$past(inData)));

  assert_cont_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!inData && !modeQuiet) |-> !driveEn);

  assert_high_follows_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && driveVal) |-> ($past(driveEn && !driveVal) && inData));

  assert_release_after_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && driveVal) |=> !driveEn);

  assert_single_low_clock_R9: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && !driveVal) |=> !(driveEn && !driveVal));

endmodule

bind serirq_agent serirq_agent_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lineIn    (lineIn),
  .driveEn   (driveEn),
  .driveVal  (driveVal),
  .modeQuiet (modeQuiet),
  .inData    (inData)
);

// File: tb/sim_serirq_agent.sv
`timescale 1ns/1ps
module sim_serirq_agent;

  localparam int NF = 4;
  localparam int SL = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqIn = 1'b0;
  logic hostVal = 1'b1;
  logic lineLvl;
  logic driveEn, driveVal, modeQuiet;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign lineLvl = hostVal & (driveEn ? driveVal : 1'b1);

  serirq_agent #(.NUM_FRAMES(NF), .SLOT(SL)) u0 (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .lineIn    (lineLvl),
    .driveEn   (driveEn),
    .driveVal  (driveVal),
    .modeQuiet (modeQuiet)
  );

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkDrive(input string req, input int expEn, input int expVal);
    chkEq(req, "driveEn", int'(driveEn), expEn);
    if (expEn != 0) chkEq(req, "driveVal", int'(driveVal), expVal);
  endtask

  // Host value for the next sampling edge; returns after that edge, mid-cycle.
  task automatic sampleHost(input logic h);
    hostVal = h;
    @(negedge clk);
  endtask

  // Start frame of lowLen samples, then a full data phase; checks every sample.
  task automatic dataPhase(input int lowLen, input logic irqv);
    irqIn = irqv;
    repeat (lowLen) sampleHost(1'b0);
    sampleHost(1'b1);               // sample H
    checkDrive("R5", 0, 0);         // H+1 is the start turnaround
    for (int j = 2; j <= 1 + 3 * NF; j++) begin
      int m, k, en, val;
      sampleHost(1'b1);
      m = (j - 2) % 3;
      k = (j - 2) / 3;
      en  = (k == SL && irqv) ? int'(m < 2) : 0;
      val = (m == 1) ? 1 : 0;
      if (k == SL && m == 0)      checkDrive("R6", en, val);
      else if (k == SL)           checkDrive("R7", en, val);
      else                        checkDrive("R5", en, val);
    end
    sampleHost(1'b1);               // last turnaround sample
    checkDrive("R5", 0, 0);
  endtask

  task automatic stopPulse(input int w, input int expQuiet);
    repeat (w) sampleHost(1'b0);
    sampleHost(1'b1);               // sample R
    chkEq((w == 2) ? "R2" : "R3", "modeQuiet", int'(modeQuiet), expQuiet);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit pulsed;
    pulsed = 1'b0;
    irqIn = 1'b1;
    hostVal = 1'b1;
    repeat (3) begin
      @(negedge clk);
      checkDrive("R1", 0, 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1", "modeQuiet", int'(modeQuiet), 0);

    // R8: continuous mode after reset, request high, idle line.
    repeat (6) begin
      sampleHost(1'b1);
      checkDrive("R8", 0, 0);
    end

    for (int iv = 0; iv < 2; iv++) begin
      for (int lenv = 4; lenv <= 6; lenv++) begin
        for (int w = 2; w <= 3; w++) begin
          logic irqv;
          irqv = logic'(iv);
          dataPhase(pulsed ? 3 : lenv, irqv);
          // R11: no start request before the stop pulse.
          irqIn = 1'b1;
          repeat (3) begin
            sampleHost(1'b1);
            checkDrive("R11", 0, 0);
          end
          irqIn = irqv;
          stopPulse(w, (w == 2) ? 1 : 0);
          checkDrive("R9", 0, 0);   // nothing at R+1
          sampleHost(1'b1);         // sample R+1
          if (w == 2 && irqv) begin
            checkDrive("R9", 1, 0); // pulse at R+2
            sampleHost(1'b0);
            checkDrive("R9", 0, 0); // released after one clock
            pulsed = 1'b1;
          end else begin
            checkDrive((w == 2) ? "R10" : "R8", 0, 0);
            repeat (3) begin
              sampleHost(1'b1);
              checkDrive((w == 2) ? "R10" : "R8", 0, 0);
            end
            pulsed = 1'b0;
          end
        end
      end
    end

    // R4: single-sample lows keep the mode in both directions.
    dataPhase(4, 1'b0);
    stopPulse(2, 1);
    sampleHost(1'b0);
    sampleHost(1'b1);
    chkEq("R4", "modeQuiet", int'(modeQuiet), 1);
    stopPulse(3, 0);
    sampleHost(1'b0);
    sampleHost(1'b1);
    chkEq("R4", "modeQuiet", int'(modeQuiet), 0);
    sampleHost(1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule